// File: doc/BRIEF.md
# Flash Write-Protection Front End

This block sits between an asynchronous parallel memory bus and the command state machine of a flash device. It decides which bus write cycles the command logic should see. The three active-low bus strobes (chip enable, write enable, output enable) are brought into the system clock domain and filtered so that short noise pulses never start or end a write. A write cycle that is accepted ends in a single-cycle qualified strobe. The strobe carries the address captured when the cycle began and the data captured when it ended.

Three protection measures share the same qualifier. A supply-lockout flag blocks all writes and holds the command logic in reset. A power-good indication resets the command logic to its read state while it is low, and a write cycle already in progress when power becomes good is discarded. A high-voltage-on-reset detect flag temporarily clears the effective protection of every sector. The stored per-sector protect bitmap is left untouched, so protection returns in full as soon as the flag drops.

Top module: `wprot_qualifier`

## Requirements
- R1: A write cycle is accepted only while chip enable is low, write enable is low and output enable is high. When that condition ends, `wr_strobe_o` is high for exactly one clock cycle.
- R2: No other held combination of the three strobes ever produces `wr_strobe_o`.
- R3: A low pulse on write enable lasting fewer than GLITCH_CYCLES clock cycles starts no write cycle. A pulse of GLITCH_CYCLES cycles or longer starts one.
- R4: A high pulse on write enable shorter than GLITCH_CYCLES cycles, inside an accepted write cycle, does not end that cycle. The cycle yields exactly one strobe.
- R5: While `lockout_i` is high, no strobe is produced and `cmd_reset_o` is high.
- R6: A write cycle that overlaps a lockout interval produces no strobe. After lockout clears, a new write cycle is accepted again.
- R7: While `pwr_ok_i` is low, `cmd_reset_o` is high and no strobe is produced. A write cycle already in progress when `pwr_ok_i` rises produces no strobe.
- R8: While `hv_det_i` is high, `eff_prot_o` is all zeros. While it is low, `eff_prot_o` equals `prot_map_i`. Bit i of both vectors belongs to sector i.
- R9: With each strobe, `cmd_addr_o` holds the address sampled at the start of the cycle and `cmd_data_o` holds the data sampled at its end.
- R10: During reset, `wr_strobe_o` is 0, `cmd_reset_o` is 1 and `eff_prot_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n_i | input | 1 | Bus chip enable, active low, asynchronous |
| we_n_i | input | 1 | Bus write enable, active low, asynchronous |
| oe_n_i | input | 1 | Bus output enable, active low, asynchronous |
| lockout_i | input | 1 | Supply below write-lockout level |
| pwr_ok_i | input | 1 | Power-up complete indication |
| hv_det_i | input | 1 | High voltage detected on the reset pin |
| prot_map_i | input | SECTORS | Stored per-sector protect bitmap, 1 = protected |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | DATA_W | Bus data |
| wr_strobe_o | output | 1 | Single-cycle qualified command write |
| cmd_addr_o | output | ADDR_W | Address of the qualified write |
| cmd_data_o | output | DATA_W | Data of the qualified write |
| cmd_reset_o | output | 1 | Reset to the command logic (to read state) |
| eff_prot_o | output | SECTORS | Effective per-sector protect mask |

## Verification
The assertions watch, on every cycle, that the strobe never lasts more than one cycle, that no strobe follows a cycle in which lockout or missing power is seen, and that the command reset tracks those flags. They also check that the effective mask never protects a sector the stored map leaves open and is empty under high voltage. Only the bench scenarios can show the glitch thresholds on both edges of a write, the handling of cycles that straddle a lockout or the power-up edge, and the address and data captured with the strobe.

// File: rtl/wp_pkg.sv
// Shared types for the write-protection front end.
// Assumes nothing beyond standard SystemVerilog enums.
package wp_pkg;
    typedef enum logic [1:0] {
        WS_IDLE    = 2'd0,
        WS_ACTIVE  = 2'd1,
        WS_BLOCKED = 2'd2
    } wr_state_t;
endpackage

// File: rtl/wp_sync.sv
// Two-flop synchronizer for a vector of asynchronous single-bit inputs.
// Assumes each bit is independent; no bus coherency is implied.
module wp_sync #(
    parameter int         WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Purpose: two-stage capture into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/wp_deglitch.sv
// Level filter: the output follows the input only after the input has
// differed from the output for CYCLES consecutive clock samples.
// Assumes the input is already synchronous to clk. CYCLES must be >= 1.
module wp_deglitch #(
    parameter int   CYCLES  = 3,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] run_q;
    logic          level_q;

    // Purpose: count consecutive disagreeing samples and flip when the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= RST_VAL;
            run_q   <= '0;
        end else if (d_i == level_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            level_q <= d_i;
            run_q   <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign q_o = level_q;
endmodule

// File: rtl/wp_write_fsm.sv
// Write-cycle tracker. A cycle that opens and closes with the gate low
// yields one strobe. A cycle seen while the gate is high is discarded
// until the bus goes inactive.
// Assumes wr_active_i is filtered and synchronous. Address must be stable
// when the cycle opens and data when it closes, as seen after filtering.
module wp_write_fsm
    import wp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_active_i,
    input  logic              gate_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              strobe_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output wr_state_t         state_o
);
    wr_state_t         state_q;
    logic              strobe_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Purpose: advance the cycle state, capture address/data and pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WS_IDLE;
            strobe_q <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
        end else begin
            strobe_q <= 1'b0;
            if (gate_i) begin
                state_q <= wr_active_i ? WS_BLOCKED : WS_IDLE;
            end else begin
                case (state_q)
                    WS_IDLE: begin
                        if (wr_active_i) begin
                            state_q <= WS_ACTIVE;
                            addr_q  <= addr_i;
                        end
                    end
                    WS_ACTIVE: begin
                        if (!wr_active_i) begin
                            state_q  <= WS_IDLE;
                            data_q   <= data_i;
                            strobe_q <= 1'b1;
                        end
                    end
                    WS_BLOCKED: begin
                        if (!wr_active_i) state_q <= WS_IDLE;
                    end
                    default: state_q <= WS_IDLE;
                endcase
            end
        end
    end

    assign strobe_o = strobe_q;
    assign addr_o   = addr_q;
    assign data_o   = data_q;
    assign state_o  = state_q;
endmodule

// File: rtl/wprot_qualifier.sv
// Top of the write-protection front end: synchronizes and filters the bus
// strobes, blocks writes under lockout or before power is good, drives the
// command-logic reset and forms the effective sector protection mask.
// Assumes the flags are glitch-free levels and prot_map_i is synchronous.
module wprot_qualifier
    import wp_pkg::*;
#(
    parameter int GLITCH_CYCLES = 3,
    parameter int SECTORS       = 8,
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_n_i,
    input  logic               we_n_i,
    input  logic               oe_n_i,
    input  logic               lockout_i,
    input  logic               pwr_ok_i,
    input  logic               hv_det_i,
    input  logic [SECTORS-1:0] prot_map_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  data_i,
    output logic               wr_strobe_o,
    output logic [ADDR_W-1:0]  cmd_addr_o,
    output logic [DATA_W-1:0]  cmd_data_o,
    output logic               cmd_reset_o,
    output logic [SECTORS-1:0] eff_prot_o
);
    localparam int NLINES = 3;   // index 0: ce, 1: we, 2: oe

    logic [NLINES-1:0] line_raw;
    logic [NLINES-1:0] line_sync;
    logic [NLINES-1:0] line_filt;
    logic [2:0]        flag_sync;
    logic              lockout_s;
    logic              pwr_s;
    logic              hv_s;
    logic              wr_active;
    logic              gate;
    logic              cmd_reset_q;
    logic [SECTORS-1:0] eff_q;
    wr_state_t         wr_state;

    assign line_raw = {oe_n_i, we_n_i, ce_n_i};

    wp_sync #(.WIDTH(NLINES), .RST_VAL({NLINES{1'b1}})) u_line_sync (
        .clk(clk), .rst_n(rst_n), .d_i(line_raw), .q_o(line_sync)
    );

    wp_sync #(.WIDTH(3), .RST_VAL(3'b000)) u_flag_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({hv_det_i, pwr_ok_i, lockout_i}), .q_o(flag_sync)
    );

    assign lockout_s = flag_sync[0];
    assign pwr_s     = flag_sync[1];
    assign hv_s      = flag_sync[2];

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        wp_deglitch #(.CYCLES(GLITCH_CYCLES), .RST_VAL(1'b1)) u_flt (
            .clk(clk), .rst_n(rst_n), .d_i(line_sync[g]), .q_o(line_filt[g])
        );
    end

    assign wr_active = !line_filt[0] && !line_filt[1] && line_filt[2];
    assign gate      = lockout_s || !pwr_s;

    wp_write_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr_active_i(wr_active), .gate_i(gate),
        .addr_i(addr_i), .data_i(data_i),
        .strobe_o(wr_strobe_o), .addr_o(cmd_addr_o), .data_o(cmd_data_o),
        .state_o(wr_state)
    );

    // Purpose: hold the command logic in reset under lockout or before power is good.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_reset_q <= 1'b1;
        else        cmd_reset_q <= lockout_s || !pwr_s;
    end

    // Purpose: clear effective protection while high voltage is present; the stored map is untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) eff_q <= '1;
        else        eff_q <= prot_map_i & ~{SECTORS{hv_s}};
    end

    assign cmd_reset_o = cmd_reset_q;
    assign eff_prot_o  = eff_q;
endmodule

// File: rtl/wp_checker.sv
// Cycle-by-cycle properties of the write-protection front end, bound to
// the top module. Assumes the internal synchronized flags named below.
module wp_checker #(
    parameter int SECTORS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lockout_s,
    input logic               pwr_s,
    input logic               hv_s,
    input logic               wr_strobe_o,
    input logic               cmd_reset_o,
    input logic [SECTORS-1:0] prot_map_i,
    input logic [SECTORS-1:0] eff_prot_o
);
    // R1: the qualified strobe never lasts two cycles
    p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe_o |=> !wr_strobe_o);

    // R5: lockout blocks the strobe
    p_lockout_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lockout_s |=> !wr_strobe_o);

    // R5: lockout holds the command logic in reset
    p_lockout_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lockout_s |=> cmd_reset_o);

    // R7: no power, no strobe
    p_nopower_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_s |=> (!wr_strobe_o && cmd_reset_o));

    // R7: reset released once power is good and lockout is clear
    p_reset_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_s && !lockout_s) |=> !cmd_reset_o);

    // R8: never protects a sector the stored map leaves open
    p_mask_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((eff_prot_o & ~$past(prot_map_i)) == '0));

    // R8: high voltage clears all effective protection
    p_hv_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hv_s |=> (eff_prot_o == '0));
endmodule

bind wprot_qualifier wp_checker #(.SECTORS(SECTORS)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .lockout_s(lockout_s), .pwr_s(pwr_s), .hv_s(hv_s),
    .wr_strobe_o(wr_strobe_o), .cmd_reset_o(cmd_reset_o),
    .prot_map_i(prot_map_i), .eff_prot_o(eff_prot_o)
);

// File: tb/tb_wprot_qualifier.sv
module tb_wprot_qualifier;
    localparam int G  = 3;
    localparam int NS = 8;
    localparam int AW = 16;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic lockout = 1'b0, pwr_ok = 1'b0, hv = 1'b0;
    logic [NS-1:0] pmap = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic wr_strobe, cmd_reset;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic [NS-1:0] eff;

    int checks = 0;
    int failures = 0;
    int strobes = 0;
    logic [AW-1:0] seen_addr = '0;
    logic [DW-1:0] seen_data = '0;

    always #5 clk = ~clk;

    wprot_qualifier #(.GLITCH_CYCLES(G), .SECTORS(NS), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
        .lockout_i(lockout), .pwr_ok_i(pwr_ok), .hv_det_i(hv), .prot_map_i(pmap),
        .addr_i(addr), .data_i(data), .wr_strobe_o(wr_strobe),
        .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data),
        .cmd_reset_o(cmd_reset), .eff_prot_o(eff)
    );

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && wr_strobe) begin
            strobes   <= strobes + 1;
            seen_addr <= cmd_addr;
            seen_data <= cmd_data;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; data = d;
        ce_n = 1'b0; oe_n = 1'b1;
        wait_cyc(2);
        we_n = 1'b0;
        wait_cyc(12);
        we_n = 1'b1;
        wait_cyc(12);
        ce_n = 1'b1;
        wait_cyc(12);
    endtask

    initial begin : watchdog
        #1500000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int base;
        wait_cyc(5);
        // R10: reset state
        check(wr_strobe == 1'b0, "R10 strobe", int'(wr_strobe), 0);
        check(cmd_reset == 1'b1, "R10 cmd_reset", int'(cmd_reset), 1);
        check(eff == '1, "R10 eff", int'(eff), 255);
        rst_n = 1'b1;
        wait_cyc(8);

        // R7: before power is good
        check(cmd_reset == 1'b1, "R7 reset without power", int'(cmd_reset), 1);
        base = strobes;
        bus_write(16'h1111, 8'h11);
        check(strobes == base, "R7 write without power", strobes - base, 0);

        // R7: write in progress when power becomes good
        base = strobes;
        ce_n = 1'b0; wait_cyc(2); we_n = 1'b0; wait_cyc(12);
        pwr_ok = 1'b1; wait_cyc(12);
        we_n = 1'b1; wait_cyc(12); ce_n = 1'b1; wait_cyc(12);
        check(strobes == base, "R7 straddling power-up", strobes - base, 0);
        check(cmd_reset == 1'b0, "R7 reset released", int'(cmd_reset), 0);

        // R1, R9: normal write with address change mid-cycle
        base = strobes;
        addr = 16'hA5C3; data = 8'h00;
        ce_n = 1'b0; wait_cyc(2); we_n = 1'b0; wait_cyc(12);
        addr = 16'h0F0F; data = 8'h7E; wait_cyc(12);
        we_n = 1'b1; wait_cyc(12);
        data = 8'h99; ce_n = 1'b1; wait_cyc(12);
        check(strobes == base + 1, "R1 one strobe", strobes - base, 1);
        check(seen_addr == 16'hA5C3, "R9 address", int'(seen_addr), 16'hA5C3);
        check(seen_data == 8'h7E, "R9 data", int'(seen_data), 8'h7E);

        // R1, R2: sweep of all held strobe combinations
        for (int c = 0; c < 8; c++) begin
            base = strobes;
            ce_n = c[0]; we_n = c[1]; oe_n = c[2];
            wait_cyc(12);
            ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
            wait_cyc(12);
            if (c == 4)
                check(strobes == base + 1, "R1 combo ce0 we0 oe1", strobes - base, 1);
            else
                check(strobes == base, "R2 combo rejected", strobes - base, 0);
        end

        // R3: write-enable low pulse width sweep
        for (int w = 1; w <= 6; w++) begin
            base = strobes;
            ce_n = 1'b0; wait_cyc(12);
            we_n = 1'b0; wait_cyc(w); we_n = 1'b1;
            wait_cyc(12); ce_n = 1'b1; wait_cyc(12);
            check(strobes == base + ((w >= G) ? 1 : 0), "R3 pulse width",
                  strobes - base, (w >= G) ? 1 : 0);
        end

        // R4: short high glitch inside a write
        for (int w = 1; w < G; w++) begin
            base = strobes;
            ce_n = 1'b0; wait_cyc(2); we_n = 1'b0; wait_cyc(12);
            we_n = 1'b1; wait_cyc(w); we_n = 1'b0; wait_cyc(12);
            we_n = 1'b1; wait_cyc(12); ce_n = 1'b1; wait_cyc(12);
            check(strobes == base + 1, "R4 glitch inside write", strobes - base, 1);
        end

        // R5: lockout
        lockout = 1'b1; wait_cyc(6);
        check(cmd_reset == 1'b1, "R5 cmd_reset under lockout", int'(cmd_reset), 1);
        base = strobes;
        bus_write(16'h2222, 8'h22);
        check(strobes == base, "R5 write under lockout", strobes - base, 0);
        lockout = 1'b0; wait_cyc(6);
        check(cmd_reset == 1'b0, "R6 reset released after lockout", int'(cmd_reset), 0);

        // R6: write straddling lockout, then normal write
        base = strobes;
        ce_n = 1'b0; wait_cyc(2); we_n = 1'b0; wait_cyc(12);
        lockout = 1'b1; wait_cyc(8); lockout = 1'b0; wait_cyc(8);
        we_n = 1'b1; wait_cyc(12); ce_n = 1'b1; wait_cyc(12);
        check(strobes == base, "R6 straddling lockout", strobes - base, 0);
        base = strobes;
        bus_write(16'h3333, 8'h33);
        check(strobes == base + 1, "R6 accepted after lockout", strobes - base, 1);

        // R8: exhaustive bitmap sweep with and without high voltage
        for (int m = 0; m < 256; m++) begin
            pmap = NS'(m);
            hv = 1'b1; wait_cyc(5);
            check(eff == '0, "R8 hv clears mask", int'(eff), 0);
            hv = 1'b0; wait_cyc(5);
            check(eff == NS'(m), "R8 mask restored", int'(eff), m);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule